// File: doc/BRIEF.md
# SPI Host Serial Engine with Power-of-Two Clock Divider

This block is the serial core of an SPI host. One control word sets clock polarity and phase, a power-of-two clock divisor, a 4-bit chip-select field and the start and slave-select policies. A separate enable input gates the whole engine. The engine takes 8-bit words from a first-word-fall-through transmit queue, shifts each one out most significant bit first, and hands every received byte to a receive queue as a single-cycle push. Once started, it keeps running through the transmit queue with no gap between bytes. When the queue is empty it returns the serial clock to its idle level.

The chip-select field can work in two ways. It can be an active-low pattern, where the lowest line held low selects the target. It can also be a binary code for an external decoder. Slave select can be driven only while a transfer is running, or held continuously by the control word. A transfer can start as soon as data is queued, or wait for an explicit go bit. A mode-fault input ends a transfer at once.

Control word layout (14 bits): bit 0 host enable, bit 1 clock polarity, bit 2 clock phase, bits [5:3] divisor code, bit 6 decoded chip-select, bits [10:7] chip-select field, bit 11 continuous slave select, bit 12 manual start enable, bit 13 go.

Top module: `spi_host_engine`

## Requirements
- R1: While reset is held, and until the first transfer, `ss_n` is 4'hF, `sclk` and `busy` are low, and `tx_pop` and `rx_push` are low.
- R2: For divisor code d (1..7) each `sclk` half period lasts 2^d reference cycles, so one byte keeps `busy` high for 16·2^d cycles. Code 0 behaves as code 1.
- R3: Bits leave on `mosi` most significant bit first. With phase 0 each bit is valid before the leading `sclk` edge and is sampled on that edge. With phase 1 each bit is driven on the leading edge and sampled on the trailing edge.
- R4: Each byte's `miso` bits, sampled on the same edges as in R3, are assembled most significant bit first and presented on `rx_data` with a one-cycle `rx_push` in the cycle after the byte's last edge. There is exactly one push per byte.
- R5: While `tx_valid` stays high at a byte boundary, the next byte follows with no break in `busy` or in the `sclk` rhythm. After the last byte, `sclk` rests at the polarity level.
- R6: A change of polarity or phase made while `enable` is high has no effect on `sclk`. While `enable` is low, `sclk` follows the polarity bit one cycle later.
- R7: A transfer starts only when `enable`, host enable (bit 0) and `tx_valid` are all high, and `tx_pop` is never high without `tx_valid`. With bit 0 low, queued data stays untouched.
- R8: With manual start enabled (bit 12), queued data waits until bit 13 is seen high. Then the transfer starts.
- R9: In active-low mode (bit 6 = 0), `ss_n` drives low only the lowest line whose field bit is 0, so at most one line is low. For example, field 4'b0101 gives 4'b1101 and field 4'b0110 gives 4'b1110.
- R10: In decoded mode (bit 6 = 1), `ss_n` carries the chip-select field unchanged.
- R11: With continuous slave select off (bit 11 = 0), `ss_n` is 4'hF whenever `busy` is low and carries the selected pattern while `busy` is high. With bit 11 = 1, the pattern is driven at all times.
- R12: A high `mode_fault` makes `busy` low and `sclk` return to the polarity level in the next cycle, and the interrupted byte is never pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 14 | Control word (layout above) |
| enable | input | 1 | Engine enable; polarity/phase are taken in only while low |
| tx_valid | input | 1 | Transmit queue holds a byte |
| tx_data | input | 8 | Head byte of the transmit queue |
| tx_pop | output | 1 | Consumes the head byte at this clock edge |
| rx_push | output | 1 | One-cycle strobe: `rx_data` holds a received byte |
| rx_data | output | 8 | Last received byte |
| mode_fault | input | 1 | Aborts the transfer immediately |
| miso | input | 1 | Serial data from the target |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the target |
| ss_n | output | 4 | Slave-select lines, active low or decoded code |
| busy | output | 1 | A transfer is in progress |

## Verification
On every cycle the assertions check the following: the abort on mode fault, the idle clock following polarity only while disabled and staying still while enabled, pops never outrunning the queue, the single-low property of active-low select, the decoded select passing through, and the deselect level outside transfers. The exact half-period length for each divisor code, the bit order and sampling edge in all four clock modes, the received byte values, back-to-back streaming and the start gating can only be shown by the bench. It runs complete transfers and compares their timing and data with values it computes from the divisor and the bytes it queued.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  // control word geometry
  localparam int CTRL_W  = 14;
  localparam int DIV_W   = 3;
  localparam int CS_W    = 4;

  // field positions inside the control word
  localparam int B_HOST   = 0;
  localparam int B_CPOL   = 1;
  localparam int B_CPHA   = 2;
  localparam int B_DIV    = 3;
  localparam int B_DECODE = 6;
  localparam int B_CS     = 7;
  localparam int B_MANSS  = 11;
  localparam int B_MANST  = 12;
  localparam int B_GO     = 13;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } eng_state_e;

endpackage

// File: rtl/spi_half_tick.sv
// Half-period timer: asserts tick on the last reference cycle of each
// sclk half period, whose length is 2^div_code cycles.
module spi_half_tick #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick
);

  localparam int CNT_W = 1 << DIV_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    last_cnt = (CNT_W'(1) << div_code) - CNT_W'(1);
    tick     = run && (cnt_q == last_cnt);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_ss_drive.sv
// Slave-select output stage: active-low single-line pick or decoded code,
// gated to the deselect level when not active.
module spi_ss_drive #(
  parameter int CS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CS_W-1:0] field,
  input  logic            decode,
  input  logic            active,
  output logic [CS_W-1:0] ss_n
);

  logic [CS_W-1:0] pick;
  logic [CS_W-1:0] ss_d;
  logic            found;

  // lowest field bit at zero wins; every other line stays high
  always_comb begin
    pick  = '1;
    found = 1'b0;
    for (int i = 0; i < CS_W; i++) begin
      if (!found && !field[i]) begin
        pick[i] = 1'b0;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    if (!active)     ss_d = '1;
    else if (decode) ss_d = field;
    else             ss_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_n <= '1;
    else        ss_n <= ss_d;
  end

endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              enable,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_data,
  input  logic              mode_fault,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [CS_W-1:0]   ss_n,
  output logic              busy
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // control fields
  logic             ctl_host, ctl_cpol, ctl_cpha, ctl_decode;
  logic             ctl_manss, ctl_manst, ctl_go;
  logic [DIV_W-1:0] ctl_div;
  logic [CS_W-1:0]  ctl_cs;

  assign ctl_host   = ctrl_word[B_HOST];
  assign ctl_cpol   = ctrl_word[B_CPOL];
  assign ctl_cpha   = ctrl_word[B_CPHA];
  assign ctl_div    = ctrl_word[B_DIV +: DIV_W];
  assign ctl_decode = ctrl_word[B_DECODE];
  assign ctl_cs     = ctrl_word[B_CS +: CS_W];
  assign ctl_manss  = ctrl_word[B_MANSS];
  assign ctl_manst  = ctrl_word[B_MANST];
  assign ctl_go     = ctrl_word[B_GO];

  // state
  eng_state_e        state_q, state_d;
  logic              cpol_q, cpol_d, cpha_q, cpha_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [WORD_W-1:0] txs_q, txs_d;
  logic [WORD_W-1:0] rxs_q, rxs_d;
  logic [WORD_W-1:0] rx_data_q, rx_data_d;
  logic [WORD_W-1:0] rx_next;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              trail_q, trail_d;
  logic              sclk_q, sclk_d;
  logic              mosi_q, mosi_d;
  logic              rx_push_q, rx_push_d;
  logic              pop_c;
  logic              start;
  logic              tick;

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .run      (state_q == ST_SHIFT),
    .div_code (div_q),
    .tick     (tick)
  );

  spi_ss_drive #(.CS_W(CS_W)) u_ss (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .field  (ctl_cs),
    .decode (ctl_decode),
    .active (ctl_manss || (state_d == ST_SHIFT)),
    .ss_n   (ss_n)
  );

  // clock mode is taken in only while the engine is disabled
  always_comb begin
    cpol_d = enable ? cpol_q : ctl_cpol;
    cpha_d = enable ? cpha_q : ctl_cpha;
    start  = (state_q == ST_IDLE) && enable && ctl_host && tx_valid &&
             !mode_fault && (!ctl_manst || ctl_go);
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    div_d     = div_q;
    txs_d     = txs_q;
    rxs_d     = rxs_q;
    rx_data_d = rx_data_q;
    bit_d     = bit_q;
    trail_d   = trail_q;
    sclk_d    = sclk_q;
    mosi_d    = mosi_q;
    rx_push_d = 1'b0;
    pop_c     = 1'b0;
    rx_next   = rxs_q;

    unique case (state_q)
      ST_IDLE: begin
        sclk_d = cpol_d;
        if (start) begin
          pop_c   = 1'b1;
          state_d = ST_SHIFT;
          div_d   = (ctl_div == '0) ? DIV_W'(1) : ctl_div;
          bit_d   = '0;
          trail_d = 1'b0;
          rxs_d   = '0;
          if (!cpha_q) begin
            mosi_d = tx_data[WORD_W-1];
            txs_d  = tx_data << 1;
          end else begin
            txs_d  = tx_data;
          end
        end
      end

      ST_SHIFT: begin
        if (!enable || mode_fault) begin
          state_d = ST_IDLE;
          sclk_d  = cpol_d;
        end else if (tick) begin
          sclk_d  = ~sclk_q;
          trail_d = ~trail_q;
          if (!trail_q) begin
            // leading edge
            if (!cpha_q) begin
              rxs_d = {rxs_q[WORD_W-2:0], miso};
            end else begin
              mosi_d = txs_q[WORD_W-1];
              txs_d  = txs_q << 1;
            end
          end else begin
            // trailing edge
            rx_next = cpha_q ? {rxs_q[WORD_W-2:0], miso} : rxs_q;
            rxs_d   = rx_next;
            if (bit_q == BIT_LAST) begin
              rx_push_d = 1'b1;
              rx_data_d = rx_next;
              bit_d     = '0;
              if (tx_valid) begin
                pop_c = 1'b1;
                if (!cpha_q) begin
                  mosi_d = tx_data[WORD_W-1];
                  txs_d  = tx_data << 1;
                end else begin
                  txs_d  = tx_data;
                end
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              bit_d = bit_q + BIT_W'(1);
              if (!cpha_q) begin
                mosi_d = txs_q[WORD_W-1];
                txs_d  = txs_q << 1;
              end
            end
          end
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q   <= ST_IDLE;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      div_q     <= DIV_W'(1);
      txs_q     <= '0;
      rxs_q     <= '0;
      rx_data_q <= '0;
      bit_q     <= '0;
      trail_q   <= 1'b0;
      sclk_q    <= 1'b0;
      mosi_q    <= 1'b0;
      rx_push_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cpol_q    <= cpol_d;
      cpha_q    <= cpha_d;
      div_q     <= div_d;
      txs_q     <= txs_d;
      rxs_q     <= rxs_d;
      rx_data_q <= rx_data_d;
      bit_q     <= bit_d;
      trail_q   <= trail_d;
      sclk_q    <= sclk_d;
      mosi_q    <= mosi_d;
      rx_push_q <= rx_push_d;
    end
  end

  assign tx_pop  = pop_c;
  assign rx_push = rx_push_q;
  assign rx_data = rx_data_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign busy    = (state_q == ST_SHIFT);

endmodule

// File: rtl/spi_host_engine_chk.sv
module spi_host_engine_chk
  import spi_host_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              enable,
  input logic              mode_fault,
  input logic              tx_valid,
  input logic              tx_pop,
  input logic              rx_push,
  input logic              busy,
  input logic              sclk,
  input logic [CS_W-1:0]   ss_n
);

  // R12
  fault_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> !busy);

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && sclk == $past(ctrl_word[B_CPOL])));

  // R6
  hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !busy && $past(enable) && !$past(busy)) |-> $stable(sclk));

  // R7
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_valid);

  // R9
  single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[B_DECODE] |=> ($countones(~ss_n) <= 1));

  // R10
  decoded_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[B_DECODE] && ctrl_word[B_MANSS]) |=>
      (ss_n == $past(ctrl_word[B_CS +: CS_W])));

  // R11
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[B_MANSS] |=> (busy || ss_n == '1));

  // R4
  push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push);

endmodule

bind spi_host_engine spi_host_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n_i),
  .ctrl_word  (ctrl_word),
  .enable     (enable),
  .mode_fault (mode_fault),
  .tx_valid   (tx_valid),
  .tx_pop     (tx_pop),
  .rx_push    (rx_push),
  .busy       (busy),
  .sclk       (sclk),
  .ss_n       (ss_n)
);

// File: tb/sim_spi_host_engine.sv
module sim_spi_host_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] ctrl;
  logic        enable;
  logic        mode_fault;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_pop;
  logic        rx_push;
  logic [7:0]  rx_data;
  logic        miso;
  logic        sclk;
  logic        mosi;
  logic [3:0]  ss_n;
  logic        busy;

  always #2 clk = ~clk;

  spi_host_engine u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_word  (ctrl),
    .enable     (enable),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_pop     (tx_pop),
    .rx_push    (rx_push),
    .rx_data    (rx_data),
    .mode_fault (mode_fault),
    .miso       (miso),
    .sclk       (sclk),
    .mosi       (mosi),
    .ss_n       (ss_n),
    .busy       (busy)
  );

  // target model: returns the inverse of what it receives
  assign miso = ~mosi;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // transmit queue model
  logic [7:0] fifo [64];
  logic [5:0] rd_ptr = '0;
  logic [5:0] wr_ptr = '0;
  assign tx_valid = (rd_ptr != wr_ptr);
  assign tx_data  = fifo[rd_ptr];

  always @(posedge clk) if (tx_pop) rd_ptr <= rd_ptr + 6'd1;

  task automatic load(input logic [7:0] b);
    fifo[wr_ptr] = b;
    wr_ptr       = wr_ptr + 6'd1;
  endtask

  // receive checker: every pushed byte is the inverse of the byte sent
  logic [5:0] rx_idx   = '0;
  int         push_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && rx_push) begin
      chk(rx_data == ~fifo[rx_idx], "R4 rx byte", rx_data, ~fifo[rx_idx]);
      rx_idx   <= rx_idx + 6'd1;
      push_cnt <= push_cnt + 1;
    end
  end

  // serial capture on the sampling edge: rising when cpol == cpha
  logic       b_cpol = 1'b0;
  logic       b_cpha = 1'b0;
  logic       cap_on = 1'b0;
  logic [7:0] cap_sh = '0;
  int         cap_n  = 0;
  logic [5:0] cap_idx = '0;
  always @(sclk) begin
    if (cap_on && (sclk == (b_cpol == b_cpha))) begin
      cap_sh = {cap_sh[6:0], mosi};
      cap_n  = cap_n + 1;
      if (cap_n == 8) begin
        chk(cap_sh == fifo[cap_idx], "R3 mosi order", cap_sh, fifo[cap_idx]);
        cap_idx = cap_idx + 6'd1;
        cap_n   = 0;
      end
    end
  end

  function automatic logic [13:0] mk(input logic host, input logic cpol,
      input logic cpha, input logic [2:0] dv, input logic dec,
      input logic [3:0] cs, input logic mss, input logic mst, input logic go);
    return {go, mst, mss, cs, dec, dv, cpha, cpol, host};
  endfunction

  // change clock mode with the engine disabled, then re-enable
  task automatic set_mode(input logic [13:0] w);
    @(negedge clk);
    enable = 1'b0;
    ctrl   = w;
    b_cpol = w[1];
    b_cpha = w[2];
    repeat (2) @(negedge clk);
    chk(sclk == w[1], "R6 idle level after disable", sclk, w[1]);
    enable = 1'b1;
    @(negedge clk);
  endtask

  // measure one transfer of n queued bytes with half period hp
  task automatic measure(input int n, input int hp);
    int w;
    int cyc;
    int p0;
    p0     = push_cnt;
    cap_on = 1'b1;
    w      = 0;
    while (!busy && w < 300) begin
      @(negedge clk);
      w++;
    end
    cyc = 0;
    while (busy) begin
      cyc++;
      @(negedge clk);
    end
    chk(cyc == 16 * n * hp, "R2/R5 busy cycles", cyc, 16 * n * hp);
    @(negedge clk);
    chk(sclk == b_cpol, "R5 sclk rests at polarity", sclk, b_cpol);
    chk(push_cnt - p0 == n, "R4 push count", push_cnt - p0, n);
    cap_on = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    enable     = 1'b0;
    mode_fault = 1'b0;
    ctrl       = mk(1, 0, 0, 3'd1, 0, 4'hF, 1, 0, 0);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ss_n == 4'hF, "R1 ss_n in reset", ss_n, 4'hF);
    chk(sclk == 1'b0, "R1 sclk in reset", sclk, 0);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(!tx_pop && !rx_push, "R1 strobes in reset", {tx_pop, rx_push}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ss_n == 4'hF && !busy, "R1 state after release", {busy, ss_n}, 4'hF);

    // R2 R3 R4: all four clock modes across every divisor code
    for (int m = 0; m < 4; m++) begin
      for (int d = 1; d < 8; d++) begin
        set_mode(mk(1, m[1], m[0], 3'(d), 0, 4'hF, 1, 0, 0));
        load(8'(d * 53) ^ {m[1:0], 6'h15});
        measure(1, 1 << d);
      end
    end

    // R2 code 0 behaves as code 1
    set_mode(mk(1, 0, 1, 3'd0, 0, 4'hF, 1, 0, 0));
    load(8'hC3);
    measure(1, 2);

    // R5 back-to-back bytes
    set_mode(mk(1, 0, 0, 3'd1, 0, 4'hF, 1, 0, 0));
    load(8'hA5); load(8'h5A); load(8'h81); load(8'h7E);
    measure(4, 2);
    set_mode(mk(1, 1, 1, 3'd2, 0, 4'hF, 1, 0, 0));
    load(8'h01); load(8'hFE);
    measure(2, 4);

    // R6 polarity change while enabled is ignored
    set_mode(mk(1, 0, 0, 3'd1, 0, 4'hF, 1, 0, 0));
    ctrl = mk(1, 1, 0, 3'd1, 0, 4'hF, 1, 0, 0);
    repeat (4) @(negedge clk);
    chk(sclk == 1'b0, "R6 polarity ignored while enabled", sclk, 0);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1, "R6 polarity applied when disabled", sclk, 1);
    set_mode(mk(1, 0, 0, 3'd1, 0, 4'hF, 1, 0, 0));

    // R7 host bit low: queued byte untouched
    ctrl = mk(0, 0, 0, 3'd1, 0, 4'hF, 1, 0, 0);
    load(8'h96);
    repeat (20) @(negedge clk);
    chk(!busy && tx_valid, "R7 no start without host bit", {busy, tx_valid}, 1);
    ctrl = mk(1, 0, 0, 3'd1, 0, 4'hF, 1, 0, 0);
    measure(1, 2);

    // R8 manual start waits for go
    ctrl = mk(1, 0, 0, 3'd1, 0, 4'hF, 1, 1, 0);
    load(8'h69);
    repeat (20) @(negedge clk);
    chk(!busy && tx_valid, "R8 waits for go", {busy, tx_valid}, 1);
    ctrl = mk(1, 0, 0, 3'd1, 0, 4'hF, 1, 1, 1);
    fork
      begin
        @(negedge clk);
        ctrl = mk(1, 0, 0, 3'd1, 0, 4'hF, 1, 1, 0);
      end
    join_none
    measure(1, 2);

    // R9 active-low pick, R10 decoded pass-through (continuous select)
    ctrl = mk(1, 0, 0, 3'd1, 0, 4'b0101, 1, 0, 0);
    repeat (2) @(negedge clk);
    chk(ss_n == 4'b1101, "R9 lowest zero wins", ss_n, 4'b1101);
    ctrl = mk(1, 0, 0, 3'd1, 0, 4'b0110, 1, 0, 0);
    repeat (2) @(negedge clk);
    chk(ss_n == 4'b1110, "R9 lowest zero wins", ss_n, 4'b1110);
    ctrl = mk(1, 0, 0, 3'd1, 1, 4'b0101, 1, 0, 0);
    repeat (2) @(negedge clk);
    chk(ss_n == 4'b0101, "R10 decoded code", ss_n, 4'b0101);
    ctrl = mk(1, 0, 0, 3'd1, 1, 4'b1010, 1, 0, 0);
    repeat (2) @(negedge clk);
    chk(ss_n == 4'b1010, "R10 decoded code", ss_n, 4'b1010);

    // R11 automatic select around a transfer
    ctrl = mk(1, 0, 0, 3'd1, 0, 4'b1011, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk(ss_n == 4'hF, "R11 deselected while idle", ss_n, 4'hF);
    load(8'h3E);
    fork
      measure(1, 2);
      begin
        repeat (10) @(negedge clk);
        chk(ss_n == 4'b1011, "R11 selected while busy", ss_n, 4'b1011);
      end
    join
    chk(ss_n == 4'hF, "R11 deselected after transfer", ss_n, 4'hF);

    // R12 mode fault aborts
    set_mode(mk(1, 1, 0, 3'd3, 0, 4'b1110, 0, 0, 0));
    begin
      int p0;
      p0 = push_cnt;
      load(8'hB7);
      repeat (20) @(negedge clk);
      chk(busy == 1'b1, "R12 transfer running", busy, 1);
      mode_fault = 1'b1;
      @(negedge clk);
      chk(!busy && sclk == 1'b1, "R12 abort to idle", {busy, sclk}, 1);
      mode_fault = 1'b0;
      repeat (200) @(negedge clk);
      chk(push_cnt == p0 && !busy, "R12 no push after abort", push_cnt - p0, 0);
      chk(ss_n == 4'hF, "R12 deselect after abort", ss_n, 4'hF);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule